// File: doc/BRIEF.md
# Periodic Protocol Control Generator

This block sits on the control side of an initiator port that follows a valid/accept handshake. The port is reused as the exit path for test responses. In functional mode every control output simply forwards the value the core drives. In test mode the outputs are replaced with fixed, free-running patterns. The interconnect then sees a legal, steady stream of write blocks and carries the response data as an ordinary guaranteed-throughput application.

Each generated control comes from a periodic source described by an active value and a period. The source shows the inverse value for period minus one cycles and the active value for one cycle, and it never looks at the accept inputs. A period of one turns the source into a constant tie-off. The word period and the block length in words are module parameters. The command period is their product, and its phase is set so that every command pulse falls on the first write pulse of its block. The accept inputs are only watched: a sticky flag records any cycle in which the interconnect failed to take a valid that was offered.

Top module: `periodic_ctrl_gen`

## Requirements
- R1: In test mode `wr_valid` is 1 on test cycles n where n mod PERIOD_O equals PERIOD_O-1 and 0 otherwise. Test cycle 0 is the first cycle with `test_mode` high after a functional cycle or after reset. When PERIOD_O is 1 it is constantly 1.
- R2: In test mode `cmd_valid` is 1 on test cycles n where n mod (BLK_WORDS·PERIOD_O) equals PERIOD_O-1, so each command coincides with the first write pulse of its block.
- R3: In test mode `cmd_blocksize` (6 bits) equals BLK_WORDS in binary, for BLK_WORDS from 1 to 63.
- R4: In test mode `cmd_addr` is all zeros, and `cmd_read` and `rd_accept` are 0.
- R5: In functional mode (`test_mode` low) each of the six control outputs equals its `func_*` input in the same cycle.
- R6: While `test_mode` is low the periodic counters are held, so every re-entry into test mode restarts both patterns at test cycle 0.
- R7: `stream_err` rises one clock after a test-mode cycle in which `cmd_valid` was 1 with `cmd_accept` 0, or `wr_valid` was 1 with `wr_accept` 0. It then stays 1 until reset.
- R8: The accept inputs have no effect on any control output. The patterns continue unchanged while accepts are withheld.
- R9: After reset `stream_err` is 0. Reset is synchronous and active low, and it also restarts the pattern phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 selects generated controls, 0 passes functional values |
| func_cmd_valid | input | 1 | Core's command valid |
| func_cmd_read | input | 1 | Core's read/write direction flag |
| func_cmd_addr | input | ADDR_W | Core's command address |
| func_cmd_blocksize | input | 6 | Core's block size |
| func_wr_valid | input | 1 | Core's write valid |
| func_rd_accept | input | 1 | Core's read accept |
| cmd_accept | input | 1 | Interconnect command accept (observed only) |
| wr_accept | input | 1 | Interconnect write accept (observed only) |
| cmd_valid | output | 1 | Command valid to the interconnect |
| cmd_read | output | 1 | Read/write direction flag |
| cmd_addr | output | ADDR_W | Command address |
| cmd_blocksize | output | 6 | Block size in words |
| wr_valid | output | 1 | Write valid |
| rd_accept | output | 1 | Read accept |
| stream_err | output | 1 | Sticky flag for a rejected valid in test mode |

## Verification
The bench goes after phase alignment. A command source that lacks its phase offset would pulse on the last write of each block rather than the first, and every block-period comparison would then mismatch. It leaves test mode and re-enters it mid-block. Counters that kept running across the gap would show a shifted write and command pattern after re-entry. Accepts are withheld both on cycles where a valid is offered and on cycles where none is. A monitor that ignored the valid would raise the flag falsely, and one that was not sticky would drop it again. Pattern checks run straight through the withheld-accept stretch, so any feedback from accept into the counters shows up as a stalled pattern.

// File: rtl/ppcg_pkg.sv
// Shared constants and helpers for the periodic protocol control generator.
package ppcg_pkg;
    localparam int unsigned BSIZE_W = 6;

    // Command period: one command per block of words.
    function automatic int unsigned cmd_period(input int unsigned word_p, input int unsigned blk);
        return word_p * blk;
    endfunction

    // Initial count that puts the first command pulse on the first write pulse.
    function automatic int unsigned cmd_phase(input int unsigned word_p, input int unsigned blk);
        return (blk - 1) * word_p;
    endfunction
endpackage

// File: rtl/pulse_gen.sv
// Generic periodic source. It outputs ~ACT for P-1 cycles and then ACT for one cycle, repeating.
// Assumes: the counter is held at PHASE while run is low; P == 1 gives a constant tie-off.
module pulse_gen #(
    parameter bit          ACT   = 1'b1,
    parameter int unsigned P     = 2,
    parameter int unsigned PHASE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);
    generate
        if (P <= 1) begin : g_tie
            logic unused_tie;
            assign unused_tie = ^{clk, rst_n, run};
            assign pulse = ACT;
        end else begin : g_cnt
            localparam int CW = $clog2(P);
            logic [CW-1:0] cnt;

            // Free-running modulo-P count, reloaded with the phase outside test mode.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt <= CW'(PHASE);
                else if (cnt == CW'(P - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign pulse = (cnt == CW'(P - 1)) ? ACT : ~ACT;

            // An active cycle is never followed by another while running.
            assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (run && pulse == ACT) |=> (!run || pulse != ACT));
        end
    endgenerate
endmodule

// File: rtl/guard_cell.sv
// Guarded output cell: forwards the functional value, or the generated value in test mode.
// Assumes: sel is stable for a whole cycle; purely combinational.
module guard_cell #(
    parameter int W = 1
) (
    input  logic         sel,
    input  logic [W-1:0] func_val,
    input  logic [W-1:0] test_val,
    output logic [W-1:0] y
);
    // Select the output source.
    always_comb y = sel ? test_val : func_val;
endmodule

// File: rtl/stream_monitor.sv
// Watches the handshake in test mode and latches an error when an offered valid is refused.
// Assumes: the interconnect must accept at the guaranteed rate; the flag clears only on reset.
module stream_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic cmd_valid,
    input  logic cmd_accept,
    input  logic wr_valid,
    input  logic wr_accept,
    output logic err
);
    logic refused;

    // A refusal is a valid without its accept in the same cycle.
    always_comb refused = test_mode && ((cmd_valid && !cmd_accept) || (wr_valid && !wr_accept));

    // Sticky error register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (refused)
            err <= 1'b1;
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !(test_mode && cmd_valid && !cmd_accept) && !(test_mode && wr_valid && !wr_accept)) |=> !err);
endmodule

// File: rtl/periodic_ctrl_gen.sv
// Top: drives an initiator port's control outputs from periodic sources during test mode.
// Assumes: 1 <= BLK_WORDS <= 63, PERIOD_O >= 1; accepts are observed, never fed back.
module periodic_ctrl_gen
    import ppcg_pkg::*;
#(
    parameter int unsigned PERIOD_O  = 3,
    parameter int unsigned BLK_WORDS = 4,
    parameter int          ADDR_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_mode,
    input  logic               func_cmd_valid,
    input  logic               func_cmd_read,
    input  logic [ADDR_W-1:0]  func_cmd_addr,
    input  logic [BSIZE_W-1:0] func_cmd_blocksize,
    input  logic               func_wr_valid,
    input  logic               func_rd_accept,
    input  logic               cmd_accept,
    input  logic               wr_accept,
    output logic               cmd_valid,
    output logic               cmd_read,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [BSIZE_W-1:0] cmd_blocksize,
    output logic               wr_valid,
    output logic               rd_accept,
    output logic               stream_err
);
    localparam int unsigned CMD_P  = cmd_period(PERIOD_O, BLK_WORDS);
    localparam int unsigned CMD_PH = cmd_phase(PERIOD_O, BLK_WORDS);

    logic gen_wr_valid, gen_cmd_valid, gen_cmd_read, gen_rd_accept;

    pulse_gen #(.ACT(1'b1), .P(PERIOD_O), .PHASE(0)) u_wr_gen (
        .clk(clk), .rst_n(rst_n), .run(test_mode), .pulse(gen_wr_valid));
    pulse_gen #(.ACT(1'b1), .P(CMD_P), .PHASE(CMD_PH)) u_cmd_gen (
        .clk(clk), .rst_n(rst_n), .run(test_mode), .pulse(gen_cmd_valid));
    pulse_gen #(.ACT(1'b0), .P(1), .PHASE(0)) u_read_gen (
        .clk(clk), .rst_n(rst_n), .run(test_mode), .pulse(gen_cmd_read));
    pulse_gen #(.ACT(1'b0), .P(1), .PHASE(0)) u_racc_gen (
        .clk(clk), .rst_n(rst_n), .run(test_mode), .pulse(gen_rd_accept));

    guard_cell #(.W(1)) u_g_cmdv (.sel(test_mode), .func_val(func_cmd_valid),
        .test_val(gen_cmd_valid), .y(cmd_valid));
    guard_cell #(.W(1)) u_g_read (.sel(test_mode), .func_val(func_cmd_read),
        .test_val(gen_cmd_read), .y(cmd_read));
    guard_cell #(.W(ADDR_W)) u_g_addr (.sel(test_mode), .func_val(func_cmd_addr),
        .test_val({ADDR_W{1'b0}}), .y(cmd_addr));
    guard_cell #(.W(BSIZE_W)) u_g_size (.sel(test_mode), .func_val(func_cmd_blocksize),
        .test_val(BSIZE_W'(BLK_WORDS)), .y(cmd_blocksize));
    guard_cell #(.W(1)) u_g_wrv (.sel(test_mode), .func_val(func_wr_valid),
        .test_val(gen_wr_valid), .y(wr_valid));
    guard_cell #(.W(1)) u_g_racc (.sel(test_mode), .func_val(func_rd_accept),
        .test_val(gen_rd_accept), .y(rd_accept));

    stream_monitor u_mon (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .cmd_valid(cmd_valid), .cmd_accept(cmd_accept),
        .wr_valid(wr_valid), .wr_accept(wr_accept), .err(stream_err));

    assert_cmd_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && cmd_valid) |-> wr_valid);
    assert_blocksize_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (cmd_blocksize == BSIZE_W'(BLK_WORDS)));
    assert_idle_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (cmd_addr == '0 && !cmd_read && !rd_accept));
    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> ({cmd_valid, cmd_read, cmd_addr, cmd_blocksize, wr_valid, rd_accept} ==
                        {func_cmd_valid, func_cmd_read, func_cmd_addr, func_cmd_blocksize,
                         func_wr_valid, func_rd_accept}));
endmodule

// File: tb/sim_periodic_ctrl_gen.sv
module sim_periodic_ctrl_gen;
    localparam int PO = 3;
    localparam int S  = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic          f_cv = 1'b0, f_rd = 1'b0, f_wv = 1'b0, f_ra = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic [5:0]    f_size = '0;
    logic          c_acc = 1'b1, w_acc = 1'b1;
    logic          cmd_valid, cmd_read, wr_valid, rd_accept, stream_err;
    logic [AW-1:0] cmd_addr;
    logic [5:0]    cmd_blocksize;

    int   n_checks = 0;
    int   n_fail = 0;
    int   tcnt = 0;
    logic exp_err = 1'b0;
    logic [31:0] pat = 32'h1234_5678;

    always #2.5 clk = ~clk;

    periodic_ctrl_gen #(.PERIOD_O(PO), .BLK_WORDS(S), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .func_cmd_valid(f_cv), .func_cmd_read(f_rd), .func_cmd_addr(f_addr),
        .func_cmd_blocksize(f_size), .func_wr_valid(f_wv), .func_rd_accept(f_ra),
        .cmd_accept(c_acc), .wr_accept(w_acc),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
        .cmd_blocksize(cmd_blocksize), .wr_valid(wr_valid), .rd_accept(rd_accept),
        .stream_err(stream_err));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model, advance the model.
    // accept_mode: 0 = always accept, 1 = withhold on idle cycles only, 2 = withhold write accept
    task automatic cyc(input logic rst, input logic tm, input int accept_mode);
        logic ew, ec;
        @(negedge clk);
        rst_n = rst;
        test_mode = tm;
        pat = pat * 32'd1103515245 + 32'd12345;
        f_cv = pat[3]; f_rd = pat[7]; f_wv = pat[11]; f_ra = pat[13];
        f_addr = pat ^ 32'hA5A5_0F0F; f_size = pat[21:16];
        ew = (tcnt % PO) == PO - 1;
        ec = (tcnt % (S * PO)) == PO - 1;
        c_acc = (accept_mode == 1) ? ec : 1'b1;
        w_acc = (accept_mode == 1) ? ew : (accept_mode == 2) ? 1'b0 : 1'b1;
        #1;
        chk("R7 err", {63'd0, stream_err}, {63'd0, exp_err});
        if (tm) begin
            chk((accept_mode != 0) ? "R8 wr_valid" : "R1 wr_valid", {63'd0, wr_valid}, {63'd0, ew});
            chk((accept_mode != 0) ? "R8 cmd_valid" : "R2 cmd_valid", {63'd0, cmd_valid}, {63'd0, ec});
            chk("R3 blocksize", {58'd0, cmd_blocksize}, 64'(S));
            chk("R4 addr/read/racc", {30'd0, cmd_addr, cmd_read, rd_accept}, 64'd0);
        end else begin
            chk("R5 passthru", {24'd0, cmd_valid, cmd_read, cmd_addr, cmd_blocksize, wr_valid, rd_accept},
                {24'd0, f_cv, f_rd, f_addr, f_size, f_wv, f_ra});
        end
        if (!rst) begin
            exp_err = 1'b0;
            tcnt = 0;
        end else begin
            if (tm && ((ec && !c_acc) || (ew && !w_acc))) exp_err = 1'b1;
            tcnt = tm ? tcnt + 1 : 0;
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 0);
        chk("R9 reset err", {63'd0, stream_err}, 64'd0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 0);     // R5 functional
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1, 0);     // R1 R2 R3 R4
        for (int i = 0; i < 5; i++)  cyc(1'b1, 1'b0, 0);
        for (int i = 0; i < 7; i++)  cyc(1'b1, 1'b1, 0);     // R6 mid-block exit
        cyc(1'b1, 1'b0, 0);
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1);     // R6 restart, R7 no false error
        chk("R7 no false err", {63'd0, stream_err}, 64'd0);
        for (int i = 0; i < 8; i++)  cyc(1'b1, 1'b1, 2);     // R7 R8 refused writes
        for (int i = 0; i < 6; i++)  cyc(1'b1, 1'b0, 0);     // R7 sticky in functional
        chk("R7 sticky", {63'd0, stream_err}, 64'd1);
        for (int i = 0; i < 2; i++)  cyc(1'b0, 1'b1, 0);     // R9 reset during test
        for (int i = 0; i < 26; i++) cyc(1'b1, 1'b1, 0);
        chk("R9 err cleared", {63'd0, stream_err}, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule